// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block takes two 32-bit binary floating-point operands and returns their rounded product together with four exception flags. The sign of the result is the exclusive-or of the operand signs. The exponents are added and the bias is taken back out. The two 24-bit significands, each with its hidden one restored, are multiplied. Since that product falls somewhere in [1, 4), a single right shift brings it back into [1, 2), and the exponent goes up by one when the shift is taken. The result is then rounded to nearest, with ties going to the even value. If rounding carries the significand up to 2.0, the block normalises a second time.

The datapath is a two-stage pipeline. Stage one classifies the operands, forms the product and computes the exponent sum. Stage two normalises, rounds and packs the result. Every operation takes exactly two cycles, and a new operand pair may be presented on every clock. The stream has no back-pressure and no ready signal. The consumer must take each result in the one cycle in which `res_valid` is high. Subnormal operands are read as zero of the same sign. A result smaller than the smallest normal value is flushed to a signed zero.

Top module: `fpm_mul`

## Requirements
- R1: `res_valid` goes high exactly two clock cycles after `op_valid` was sampled high, with one result for each accepted pair. Back-to-back pairs are accepted every cycle, and reset clears `res_valid`.
- R2: The sign bit (bit 31) of every non-NaN result equals the exclusive-or of the two operand sign bits. This includes zero and infinity results.
- R3: A finite product whose significand product lies in [1, 2) keeps the exponent sum unchanged. Example: 1.25 × 1.25 gives 0x3FC80000.
- R4: A significand product in [2, 4) is shifted right by one and the exponent is incremented. Example: 1.5 × 1.5 gives 0x40100000.
- R5: Rounding is to nearest. An exact halfway case rounds to the value whose lowest fraction bit is 0.
- R6: A round-up that carries the significand to 2.0 is renormalised, which increments the exponent once more. Example: 0x3F800001 × 0x3FFFFFFE gives 0x40000000.
- R7: A final biased exponent of 255 or more returns a signed infinity with the overflow and inexact flags set. The block checks this both right after the exponent add and after normalisation and rounding.
- R8: A final biased exponent below 1 returns a signed zero with the underflow and inexact flags set. An exact result at the smallest normal value (0x00800000) raises no flag.
- R9: A NaN in either operand returns the quiet NaN 0x7FC00000. It raises no flag, unless R10 also applies.
- R10: Zero times infinity, in either order, returns 0x7FC00000 and sets the invalid flag.
- R11: Infinity times a nonzero non-NaN operand returns a signed infinity with no flag. Zero times a finite operand returns a signed zero with no flag. Subnormal operands behave as zero.
- R12: The inexact flag is set on a normal result exactly when nonzero bits were discarded by rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 32 | First operand, binary32 |
| op_b | input | 32 | Second operand, binary32 |
| res_valid | output | 1 | Result present this cycle |
| res_word | output | 32 | Rounded product, binary32 |
| flag_invalid | output | 1 | Invalid operation (zero times infinity) |
| flag_overflow | output | 1 | Result too large, infinity returned |
| flag_underflow | output | 1 | Result below smallest normal, zero returned |
| flag_inexact | output | 1 | Returned value differs from the exact product |

## Verification
The hardest cases to reach from the pins are the ones where normalisation alone decides the outcome. One is a pair whose exponent sum lands exactly on 254 but whose significand product is at least 2, so overflow appears only after the shift. Another is a product just below 2.0 that rounding carries over into the next binade. Neither case shows up with ordinary operands. The stimulus builds them from chosen significands: 1.5 × 1.5 on top of a large exponent, and (1 + 2^-23) × (2 − 2^-22). It also builds exact halfway products (1.5 times 1 + 2^-23, and 1.5 times 1 + 3·2^-23) so that both directions of the ties-to-even rule are exercised. The whole table is streamed back to back so that the pipeline stages hold different cases at the same time.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int ESUM_W = EXP_W + 3;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP = (1 << EXP_W) - 1;

  typedef struct packed {
    logic              sign;
    logic              zero;
    logic              inf;
    logic              nan;
    logic [EXP_W-1:0]  exp;
    logic [SIG_W-1:0]  sig;
  } fpm_opnd_t;

  typedef struct packed {
    logic invalid;
    logic overflow;
    logic underflow;
    logic inexact;
  } fpm_flags_t;
endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fpm_opnd_t         opnd
);
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic              e_ones;

  always_comb begin
    e      = word[WORD_W-2 -: EXP_W];
    f      = word[FRAC_W-1:0];
    e_ones = &e;
    opnd.sign = word[WORD_W-1];
    opnd.exp  = e;
    opnd.sig  = {1'b1, f};
    // subnormal operands are read as zero
    opnd.zero = (e == '0);
    opnd.inf  = e_ones && (f == '0);
    opnd.nan  = e_ones && (f != '0);
  end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
  import fpm_pkg::*;
(
  input  logic [PROD_W-1:0]        prod,
  input  logic signed [ESUM_W-1:0] esum,
  output logic signed [ESUM_W-1:0] exp_fin,
  output logic [FRAC_W-1:0]        frac,
  output logic                     inexact
);
  logic             hi;
  logic [SIG_W-1:0] mant;
  logic             guard;
  logic             sticky;
  logic             rnd_up;
  logic [SIG_W:0]   sum;
  logic             carry;

  always_comb begin
    hi = prod[PROD_W-1];
    if (hi) begin
      mant   = prod[PROD_W-1 -: SIG_W];
      guard  = prod[SIG_W-1];
      sticky = |prod[SIG_W-2:0];
    end else begin
      mant   = prod[PROD_W-2 -: SIG_W];
      guard  = prod[SIG_W-2];
      sticky = |prod[SIG_W-3:0];
    end
    rnd_up  = guard & (sticky | mant[0]);
    sum     = {1'b0, mant} + {{SIG_W{1'b0}}, rnd_up};
    carry   = sum[SIG_W];
    frac    = carry ? sum[FRAC_W:1] : sum[FRAC_W-1:0];
    exp_fin = esum + ESUM_W'(hi) + ESUM_W'(carry);
    inexact = guard | sticky;
  end
endmodule

// File: rtl/fpm_pack.sv
module fpm_pack
  import fpm_pkg::*;
(
  input  logic                     sign,
  input  logic                     is_nan,
  input  logic                     is_inv,
  input  logic                     is_inf,
  input  logic                     is_zero,
  input  logic                     ovf_early,
  input  logic                     unf_early,
  input  logic signed [ESUM_W-1:0] exp_fin,
  input  logic [FRAC_W-1:0]        frac,
  input  logic                     inexact,
  output logic [WORD_W-1:0]        word,
  output fpm_flags_t               flags
);
  localparam logic signed [ESUM_W-1:0] EXP_TOP_S = ESUM_W'(EXP_TOP);
  localparam logic signed [ESUM_W-1:0] ONE_S     = ESUM_W'(1);
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic ovf;
  logic unf;

  always_comb begin
    ovf   = ovf_early | (exp_fin >= EXP_TOP_S);
    unf   = unf_early | (exp_fin < ONE_S);
    word  = {sign, exp_fin[EXP_W-1:0], frac};
    flags = '0;
    flags.inexact = inexact;
    if (is_nan) begin
      word  = QNAN;
      flags = '0;
      flags.invalid = is_inv;
    end else if (is_inf) begin
      word  = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      flags = '0;
    end else if (is_zero) begin
      word  = {sign, {(WORD_W-1){1'b0}}};
      flags = '0;
    end else if (ovf) begin
      word  = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      flags.overflow = 1'b1;
      flags.inexact  = 1'b1;
    end else if (unf) begin
      word  = {sign, {(WORD_W-1){1'b0}}};
      flags.underflow = 1'b1;
      flags.inexact   = 1'b1;
    end
  end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              flag_invalid,
  output logic              flag_overflow,
  output logic              flag_underflow,
  output logic              flag_inexact
);
  localparam logic signed [ESUM_W-1:0] BIAS_S    = ESUM_W'(BIAS);
  localparam logic signed [ESUM_W-1:0] EXP_TOP_S = ESUM_W'(EXP_TOP);
  localparam logic signed [ESUM_W-1:0] UNF_S     = -ESUM_W'(1);
  localparam int EPAD = ESUM_W - EXP_W;

  fpm_opnd_t opa, opb;

  fpm_classify u_cls_a (.word(op_a), .opnd(opa));
  fpm_classify u_cls_b (.word(op_b), .opnd(opb));

  // stage one: product, exponent sum, special classes
  logic signed [ESUM_W-1:0] esum_c;
  logic nan_c, inv_c, inf_c, zero_c;

  always_comb begin
    esum_c = signed'({{EPAD{1'b0}}, opa.exp}) + signed'({{EPAD{1'b0}}, opb.exp}) - BIAS_S;
    inv_c  = (opa.zero & opb.inf) | (opa.inf & opb.zero);
    nan_c  = opa.nan | opb.nan | inv_c;
    inf_c  = (opa.inf | opb.inf) & ~nan_c;
    zero_c = (opa.zero | opb.zero) & ~nan_c;
  end

  logic                     s1_valid;
  logic                     s1_sign;
  logic [PROD_W-1:0]        s1_prod;
  logic signed [ESUM_W-1:0] s1_esum;
  logic                     s1_ovf, s1_unf;
  logic                     s1_nan, s1_inv, s1_inf, s1_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_prod  <= '0;
      s1_esum  <= '0;
      s1_ovf   <= 1'b0;
      s1_unf   <= 1'b0;
      s1_nan   <= 1'b0;
      s1_inv   <= 1'b0;
      s1_inf   <= 1'b0;
      s1_zero  <= 1'b0;
    end else begin
      s1_valid <= op_valid;
      s1_sign  <= opa.sign ^ opb.sign;
      s1_prod  <= opa.sig * opb.sig;
      s1_esum  <= esum_c;
      // early range check at the exponent add: normalisation adds at most two
      s1_ovf   <= (esum_c >= EXP_TOP_S);
      s1_unf   <= (esum_c < UNF_S);
      s1_nan   <= nan_c;
      s1_inv   <= inv_c;
      s1_inf   <= inf_c;
      s1_zero  <= zero_c;
    end
  end

  // stage two: normalise, round, pack
  logic signed [ESUM_W-1:0] exp_fin;
  logic [FRAC_W-1:0]        frac_r;
  logic                     inx_r;
  logic [WORD_W-1:0]        word_c;
  fpm_flags_t               flags_c;

  fpm_round u_round (
    .prod(s1_prod), .esum(s1_esum),
    .exp_fin(exp_fin), .frac(frac_r), .inexact(inx_r)
  );

  fpm_pack u_pack (
    .sign(s1_sign), .is_nan(s1_nan), .is_inv(s1_inv), .is_inf(s1_inf),
    .is_zero(s1_zero), .ovf_early(s1_ovf), .unf_early(s1_unf),
    .exp_fin(exp_fin), .frac(frac_r), .inexact(inx_r),
    .word(word_c), .flags(flags_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_word       <= '0;
      flag_invalid   <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_underflow <= 1'b0;
      flag_inexact   <= 1'b0;
    end else begin
      res_valid      <= s1_valid;
      res_word       <= word_c;
      flag_invalid   <= flags_c.invalid;
      flag_overflow  <= flags_c.overflow;
      flag_underflow <= flags_c.underflow;
      flag_inexact   <= flags_c.inexact;
    end
  end
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk
  import fpm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              sign_a,
  input logic              sign_b,
  input logic              res_valid,
  input logic [WORD_W-1:0] res_word,
  input logic              flag_invalid,
  input logic              flag_overflow,
  input logic              flag_underflow,
  input logic              flag_inexact
);
  localparam logic [WORD_W-1:0] QNAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic vp1, vp2, sx1, sx2;
  logic res_is_nan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp1 <= 1'b0; vp2 <= 1'b0; sx1 <= 1'b0; sx2 <= 1'b0;
    end else begin
      vp1 <= op_valid; vp2 <= vp1;
      sx1 <= sign_a ^ sign_b; sx2 <= sx1;
    end
  end

  assign res_is_nan = (&res_word[WORD_W-2 -: EXP_W]) && (res_word[FRAC_W-1:0] != '0);

  // R1
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == vp2);

  // R2
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_is_nan) |-> (res_word[WORD_W-1] == sx2));

  // R7
  overflow_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_overflow) |->
      (res_word[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}) && flag_inexact);

  // R8
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_underflow) |-> (res_word[WORD_W-2:0] == '0) && flag_inexact);

  // R10
  invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_invalid) |-> (res_word == QNAN) && !flag_inexact);

  // R7 R8 R10
  exclusive_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0({flag_invalid, flag_overflow, flag_underflow}));
endmodule

bind fpm_mul fpm_mul_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid),
  .sign_a(op_a[31]), .sign_b(op_b[31]),
  .res_valid(res_valid), .res_word(res_word),
  .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
  .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
);

// File: tb/fpm_mul_bench.sv
module fpm_mul_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 21;

  // flags packed as {invalid, overflow, underflow, inexact}
  localparam logic [31:0] VA [N] = '{
    32'h3F800000, 32'h3FA00000, 32'h3FC00000, 32'h40400000, 32'hC0000000,
    32'h3FC00000, 32'h3FC00000, 32'h3F800001, 32'h3F800001, 32'h7F000000,
    32'hFF400000, 32'h00800000, 32'h80800000, 32'h00800000, 32'h00000000,
    32'h7FC00001, 32'h7F800000, 32'h80000000, 32'h00000001, 32'h3F800000,
    32'hFF800000};
  localparam logic [31:0] VB [N] = '{
    32'h3F800000, 32'h3FA00000, 32'h3FC00000, 32'h40A00000, 32'h40400000,
    32'h3F800001, 32'h3F800003, 32'h3FFFFFFE, 32'h3F800001, 32'h7F000000,
    32'h3FC00000, 32'h3F000000, 32'h3F000000, 32'h3F800000, 32'h7F800000,
    32'h3F800000, 32'hC0000000, 32'h40A00000, 32'h40000000, 32'h7F800001,
    32'h80000000};
  localparam logic [31:0] VR [N] = '{
    32'h3F800000, 32'h3FC80000, 32'h40100000, 32'h41700000, 32'hC0C00000,
    32'h3FC00002, 32'h3FC00004, 32'h40000000, 32'h3F800002, 32'h7F800000,
    32'hFF800000, 32'h00000000, 32'h80000000, 32'h00800000, 32'h7FC00000,
    32'h7FC00000, 32'hFF800000, 32'h80000000, 32'h00000000, 32'h7FC00000,
    32'h7FC00000};
  localparam logic [3:0] VF [N] = '{
    4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
    4'b0001, 4'b0001, 4'b0001, 4'b0001, 4'b0101,
    4'b0101, 4'b0011, 4'b0011, 4'b0000, 4'b1000,
    4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
    4'b1000};
  // R3 R3 R4 R3 R2 | R5 R5 R6 R12 R7 | R7 R8 R8 R8 R10 | R9 R11 R11 R11 R9 | R10
  localparam int VT [N] = '{3, 3, 4, 3, 2, 5, 5, 6, 12, 7, 7, 8, 8, 8, 10, 9, 11, 11, 11, 9, 10};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic res_valid;
  logic [31:0] res_word;
  logic f_inv, f_ovf, f_unf, f_inx;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpm_mul u_fpm_mul (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
    .res_valid(res_valid), .res_word(res_word),
    .flag_invalid(f_inv), .flag_overflow(f_ovf),
    .flag_underflow(f_unf), .flag_inexact(f_inx)
  );

  task automatic check(input bit ok, input int req, input logic [36:0] act, input logic [36:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_sample();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state, R1
    repeat (3) step_sample();
    check(res_valid == 1'b0, 1, {36'b0, res_valid}, 37'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // table streamed back to back; output of row i appears two cycles later
    for (int i = 0; i <= N; i++) begin
      @(negedge clk);
      if (i < N) begin
        op_valid = 1'b1; op_a = VA[i]; op_b = VB[i];
      end else begin
        op_valid = 1'b0; op_a = '0; op_b = '0;
      end
      step_sample();
      if (i >= 1) begin
        check(res_valid && res_word == VR[i-1] && {f_inv, f_ovf, f_unf, f_inx} == VF[i-1],
              VT[i-1], {res_valid, res_word, f_inv, f_ovf, f_unf, f_inx},
              {1'b1, VR[i-1], VF[i-1]});
      end
    end

    // R1: single pulse gives exactly one result two cycles later
    @(negedge clk);
    op_valid = 1'b1; op_a = 32'h40000000; op_b = 32'h40400000;
    step_sample();
    @(negedge clk);
    op_valid = 1'b0;
    check(res_valid == 1'b0, 1, {36'b0, res_valid}, 37'b0);
    step_sample();
    check(res_valid == 1'b1 && res_word == 32'h40C00000, 1,
          {res_valid, res_word, 4'b0}, {1'b1, 32'h40C00000, 4'b0});
    step_sample();
    check(res_valid == 1'b0, 1, {36'b0, res_valid}, 37'b0);

    // R1: reset drops a result in flight
    @(negedge clk);
    op_valid = 1'b1; op_a = 32'h3F800000; op_b = 32'h3F800000;
    step_sample();
    @(negedge clk);
    op_valid = 1'b0; rst_n = 1'b0;
    step_sample();
    @(negedge clk);
    rst_n = 1'b1;
    check(res_valid == 1'b0, 1, {36'b0, res_valid}, 37'b0);
    step_sample();
    check(res_valid == 1'b0, 1, {36'b0, res_valid}, 37'b0);

    // R2: negative times negative, product in shift range (-1.5 * -1.5)
    @(negedge clk);
    op_valid = 1'b1; op_a = 32'hBFC00000; op_b = 32'hBFC00000;
    step_sample();
    @(negedge clk);
    op_valid = 1'b0;
    step_sample();
    check(res_valid && res_word == 32'h40100000, 2,
          {res_valid, res_word, 4'b0}, {1'b1, 32'h40100000, 4'b0});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule